// File: doc/BRIEF.md
# Integer ALU with Status Flag Register

This block is a 32-bit integer arithmetic and logic unit with a six-bit status flag register beside it. Each operation acts on an 8-bit, 16-bit or 32-bit slice of the operands. The result appears combinationally in the same cycle the operation is presented. The flag register takes its new value on the rising clock edge that closes that cycle. A write-back enable tells the surrounding datapath whether the result is to be stored.

The arithmetic group covers add, add with carry-in, subtract, subtract with borrow-in, increment, decrement, two's-complement negate and compare. The logic group covers bitwise AND, bitwise OR and one's-complement invert. A separate group of opcodes manipulates the flags directly:

- force the carry flag to 1 or to 0;
- pack the flags into a byte;
- unpack a byte into the flags;
- expand carry into an all-ones or all-zeros byte.

The block has no state machine. Its only state is the flag register, which has two behaviours. When `op_valid` is high it loads the next-flag value computed for that operation. When `op_valid` is low it holds its value.

Top module: `flag_alu`

Opcode encoding (`opcode`):

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | add with carry |
| 2 | subtract |
| 3 | subtract with borrow |
| 4 | increment |
| 5 | decrement |
| 6 | negate |
| 7 | invert |
| 8 | AND |
| 9 | OR |
| 10 | compare |
| 11 | set carry |
| 12 | clear carry |
| 13 | flags to byte |
| 14 | byte to flags |
| 15 | carry to byte |

Operand size (`size`): 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.

Flag vector bits (`flags`):

| Bit | Flag |
|-----|------|
| 0 | CF |
| 1 | PF |
| 2 | AF |
| 3 | ZF |
| 4 | SF |
| 5 | OF |

## Requirements
- R1: Add yields A+B and add-with-carry yields A+B+CF, both over the selected size. Result bits above the size are 0. CF is set exactly when a carry leaves the most significant bit of the size.
- R2: Subtract yields A-B and subtract-with-borrow yields A-B-CF, both over the selected size. CF is set exactly when a borrow leaves the most significant bit of the size.
- R3: For arithmetic operations, OF is set exactly when the signed two's-complement result falls outside the range of the selected size.
- R4: For arithmetic and logic operations, ZF is set when the sized result is zero. SF equals the result bit at the top of the size. PF is set when bits 7..0 of the result hold an even number of ones, for every size.
- R5: For arithmetic operations, AF is set exactly when a carry or borrow leaves bit 3.
- R6: Increment and decrement keep CF at its prior value and update OF, AF, ZF, SF and PF as for A+1 and A-1.
- R7: Compare sets all six flags as subtract does. It drives `wr_en` low and `result` to 0.
- R8: Negate yields 0-A, sets CF unless A is zero, and sets the other flags as that subtraction does. Invert yields the bitwise complement within the size and leaves every flag unchanged.
- R9: AND and OR clear CF and OF, keep AF, and set ZF, SF and PF from the result.
- R10: Flags-to-byte returns a byte laid out, from bit 7 down to bit 0, as SF, ZF, 0, AF, 0, PF, 1, CF, with `wr_en` high. It changes no flag.
- R11: Byte-to-flags loads SF, ZF, AF, PF and CF from bits 7, 6, 4, 2 and 0 of A. It keeps OF, drives `wr_en` low and drives `result` to 0.
- R12: Carry-to-byte returns 0xFF when CF is 1 and 0x00 when CF is 0, with `wr_en` high and no flag change. Set-carry and clear-carry make CF 1 and 0 respectively, touch no other flag, and drive `wr_en` low.
- R13: Reset clears all flags. Flags change only on a clock edge where `op_valid` is high. While `op_valid` is low, `wr_en` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code, see table |
| size | input | 2 | Operand size select |
| opa | input | 32 | First operand (destination side) |
| opb | input | 32 | Second operand (source side) |
| result | output | 32 | Sized result, zero-extended |
| wr_en | output | 1 | Result is to be written back |
| flags | output | 6 | Flag register {OF,SF,ZF,AF,PF,CF} |

## Verification
`result` and `wr_en` are combinational, so they are due in the same cycle the operation is presented. The bench drives each operation on a falling edge and samples them shortly before the next rising edge. The flags are due one rising edge later, so the bench samples `flags` on the falling edge that follows. A model of the flag register in the bench carries CF and the other flags forward. Add-with-carry and similar operations are therefore checked against whatever flag state the preceding operation left behind.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
    localparam int DATA_W  = 32;
    localparam int FLAG_N  = 6;
    localparam int OP_W    = 4;
    localparam int SIZE_W  = 2;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(DATA_W) + 1;

    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_AF = 2;
    localparam int FL_ZF = 3;
    localparam int FL_SF = 4;
    localparam int FL_OF = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SBB   = 4'd3,
        OP_INC   = 4'd4,
        OP_DEC   = 4'd5,
        OP_NEG   = 4'd6,
        OP_INV   = 4'd7,
        OP_AND   = 4'd8,
        OP_OR    = 4'd9,
        OP_CMP   = 4'd10,
        OP_SETC  = 4'd11,
        OP_CLRC  = 4'd12,
        OP_F2B   = 4'd13,
        OP_B2F   = 4'd14,
        OP_C2B   = 4'd15
    } alu_op_e;

    typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/flag_alu_core.sv
module flag_alu_core
    import flag_alu_pkg::*;
(
    input  logic [OP_W-1:0]   opcode,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  flag_vec_t         flags_q,
    output logic [DATA_W-1:0] res,
    output logic              res_wr,
    output flag_vec_t         flags_d
);
    logic [DATA_W-1:0] mask;
    logic [IDX_W-1:0]  msb;
    logic [IDX_W-1:0]  cidx;
    logic [DATA_W-1:0] ax, bx;
    logic              cin, do_sub, is_arith, keep_c;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] ares;
    logic              c_out, a_out, o_out;
    logic [DATA_W-1:0] lres;
    alu_op_e           op;

    assign op = alu_op_e'(opcode);

    // operand width decode
    always_comb begin
        unique case (size)
            2'd0:    begin mask = {{(DATA_W-8){1'b0}},  {8{1'b1}}};  msb = IDX_W'(7);  end
            2'd1:    begin mask = {{(DATA_W-16){1'b0}}, {16{1'b1}}}; msb = IDX_W'(15); end
            default: begin mask = {DATA_W{1'b1}};                    msb = IDX_W'(DATA_W-1); end
        endcase
        cidx = msb + IDX_W'(1);
    end

    // operand steering for the shared adder
    always_comb begin
        ax       = opa & mask;
        bx       = opb & mask;
        cin      = 1'b0;
        do_sub   = 1'b0;
        is_arith = 1'b1;
        keep_c   = 1'b0;
        unique case (op)
            OP_ADD: ;
            OP_ADC: cin = flags_q[FL_CF];
            OP_SUB, OP_CMP: do_sub = 1'b1;
            OP_SBB: begin do_sub = 1'b1; cin = flags_q[FL_CF]; end
            OP_INC: begin bx = {{(DATA_W-1){1'b0}}, 1'b1}; keep_c = 1'b1; end
            OP_DEC: begin bx = {{(DATA_W-1){1'b0}}, 1'b1}; keep_c = 1'b1; do_sub = 1'b1; end
            OP_NEG: begin ax = '0; bx = opa & mask; do_sub = 1'b1; end
            default: is_arith = 1'b0;
        endcase
    end

    // shared adder and arithmetic flag terms
    always_comb begin
        if (do_sub)
            sum = {1'b0, ax} - {1'b0, bx} - {{DATA_W{1'b0}}, cin};
        else
            sum = {1'b0, ax} + {1'b0, bx} + {{DATA_W{1'b0}}, cin};
        ares  = sum[DATA_W-1:0] & mask;
        c_out = sum[cidx];
        a_out = ax[4] ^ bx[4] ^ sum[4];
        if (do_sub)
            o_out = (ax[msb] != bx[msb]) && (ares[msb] != ax[msb]);
        else
            o_out = (ax[msb] == bx[msb]) && (ares[msb] != ax[msb]);
        lres = (op == OP_AND) ? (opa & opb & mask) : ((opa | opb) & mask);
    end

    // result, write-back and next flags
    always_comb begin
        res     = '0;
        res_wr  = 1'b0;
        flags_d = flags_q;
        if (is_arith) begin
            res    = (op == OP_CMP) ? '0 : ares;
            res_wr = (op != OP_CMP);
            flags_d[FL_CF] = keep_c ? flags_q[FL_CF] : c_out;
            flags_d[FL_OF] = o_out;
            flags_d[FL_AF] = a_out;
            flags_d[FL_ZF] = (ares == '0);
            flags_d[FL_SF] = ares[msb];
            flags_d[FL_PF] = ~^ares[BYTE_W-1:0];
        end else begin
            unique case (op)
                OP_INV: begin
                    res    = ~opa & mask;
                    res_wr = 1'b1;
                end
                OP_AND, OP_OR: begin
                    res    = lres;
                    res_wr = 1'b1;
                    flags_d[FL_CF] = 1'b0;
                    flags_d[FL_OF] = 1'b0;
                    flags_d[FL_ZF] = (lres == '0);
                    flags_d[FL_SF] = lres[msb];
                    flags_d[FL_PF] = ~^lres[BYTE_W-1:0];
                end
                OP_SETC: flags_d[FL_CF] = 1'b1;
                OP_CLRC: flags_d[FL_CF] = 1'b0;
                OP_F2B: begin
                    res    = {{(DATA_W-BYTE_W){1'b0}}, flags_q[FL_SF], flags_q[FL_ZF], 1'b0,
                              flags_q[FL_AF], 1'b0, flags_q[FL_PF], 1'b1, flags_q[FL_CF]};
                    res_wr = 1'b1;
                end
                OP_B2F: begin
                    flags_d[FL_SF] = opa[7];
                    flags_d[FL_ZF] = opa[6];
                    flags_d[FL_AF] = opa[4];
                    flags_d[FL_PF] = opa[2];
                    flags_d[FL_CF] = opa[0];
                end
                OP_C2B: begin
                    res    = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{flags_q[FL_CF]}}};
                    res_wr = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flag_alu_freg.sv
module flag_alu_freg
    import flag_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  flag_vec_t flags_d,
    output flag_vec_t flags_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else if (load)
            flags_q <= flags_d;
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags_q)); // R13
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [OP_W-1:0]     opcode,
    input  logic [SIZE_W-1:0]   size,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    output logic [DATA_W-1:0]   result,
    output logic                wr_en,
    output logic [FLAG_N-1:0]   flags
);
    logic [DATA_W-1:0] core_res;
    logic              core_wr;
    flag_vec_t         nxt_flags;
    flag_vec_t         cur_flags;

    flag_alu_core u_core (
        .opcode  (opcode),
        .size    (size),
        .opa     (opa),
        .opb     (opb),
        .flags_q (cur_flags),
        .res     (core_res),
        .res_wr  (core_wr),
        .flags_d (nxt_flags)
    );

    flag_alu_freg u_freg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (op_valid),
        .flags_d (nxt_flags),
        .flags_q (cur_flags)
    );

    assign result = op_valid ? core_res : '0;
    assign wr_en  = op_valid & core_wr;
    assign flags  = cur_flags;

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_CMP) |-> (!wr_en && result == '0)); // R7
    AST_INCDEC_KEEP_CF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode == OP_INC || opcode == OP_DEC)) |=> (flags[FL_CF] == $past(flags[FL_CF]))); // R6
    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode == OP_AND || opcode == OP_OR)) |=> (!flags[FL_CF] && !flags[FL_OF])); // R9
    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && size == 2'd0) |-> (result[DATA_W-1:BYTE_W] == '0)); // R1
    AST_PACK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_F2B) |-> (result[1] && !result[3] && !result[5] && wr_en)); // R10
    AST_C2B_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_C2B) |-> (result == (flags[FL_CF] ? 32'hFF : 32'h0))); // R12
    AST_SETC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_SETC) |=> flags[FL_CF]); // R12
    AST_INV_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_INV) |=> $stable(flags)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!wr_en && result == '0)); // R13
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
    import flag_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [1:0]  size = '0;
    logic [31:0] opa = '0, opb = '0;
    logic [31:0] result;
    logic        wr_en;
    logic [5:0]  flags;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [5:0] mflags = '0;

    flag_alu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .size(size), .opa(opa), .opb(opb), .result(result), .wr_en(wr_en), .flags(flags)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            bad++;
            total++;
            $display("FAIL R13 watchdog: actual cycles=%0d expected below 190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Reference model, arithmetic on wide signed integers
    task automatic model(input logic [3:0] op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b, input logic [5:0] fin,
                         output logic [31:0] r, output logic w, output logic [5:0] fo);
        int     nb;
        longint m, half, x, y, c, t, sx, sy, sr;
        logic   ar, sb, kc;
        nb   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m    = (longint'(1) << nb) - 1;
        half = longint'(1) << (nb - 1);
        x = longint'(a) & m;
        y = longint'(b) & m;
        c = 0; ar = 1'b1; sb = 1'b0; kc = 1'b0;
        fo = fin; r = '0; w = 1'b0;
        case (op)
            4'd0: ;
            4'd1: c = fin[0];
            4'd2, 4'd10: sb = 1'b1;
            4'd3: begin sb = 1'b1; c = fin[0]; end
            4'd4: begin y = 1; kc = 1'b1; end
            4'd5: begin y = 1; kc = 1'b1; sb = 1'b1; end
            4'd6: begin y = x; x = 0; sb = 1'b1; end
            default: ar = 1'b0;
        endcase
        if (ar) begin
            sx = (x >= half) ? x - 2*half : x;
            sy = (y >= half) ? y - 2*half : y;
            if (sb) begin
                t = x - y - c; sr = sx - sy - c;
                if (!kc) fo[0] = (t < 0);
                fo[2] = ((x & 15) - (y & 15) - c) < 0;
            end else begin
                t = x + y + c; sr = sx + sy + c;
                if (!kc) fo[0] = ((t >> nb) & 1) != 0;
                fo[2] = ((x & 15) + (y & 15) + c) > 15;
            end
            fo[5] = (sr >= half) || (sr < -half);
            r = 32'(t & m);
            fo[3] = (r == 0);
            fo[4] = r[nb-1];
            fo[1] = ($countones(r[7:0]) % 2) == 0;
            w = (op != 4'd10);
            if (op == 4'd10) r = '0;
        end else begin
            case (op)
                4'd7: begin r = 32'(~x & m); w = 1'b1; end
                4'd8, 4'd9: begin
                    r = (op == 4'd8) ? 32'(x & y) : 32'(x | y);
                    w = 1'b1;
                    fo[0] = 1'b0; fo[5] = 1'b0;
                    fo[3] = (r == 0); fo[4] = r[nb-1];
                    fo[1] = ($countones(r[7:0]) % 2) == 0;
                end
                4'd11: fo[0] = 1'b1;
                4'd12: fo[0] = 1'b0;
                4'd13: begin r = {24'd0, fin[4], fin[3], 1'b0, fin[2], 1'b0, fin[1], 1'b1, fin[0]}; w = 1'b1; end
                4'd14: begin fo[4] = a[7]; fo[3] = a[6]; fo[2] = a[4]; fo[1] = a[2]; fo[0] = a[0]; end
                default: begin r = fin[0] ? 32'hFF : 32'h0; w = 1'b1; end
            endcase
        end
    endtask

    function automatic string res_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R1";
            4'd2, 4'd3: return "R2";
            4'd4, 4'd5: return "R6";
            4'd6, 4'd7: return "R8";
            4'd8, 4'd9: return "R9";
            4'd10: return "R7";
            4'd13: return "R10";
            4'd14: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic string flag_tag(input logic [3:0] op, input logic [5:0] got, input logic [5:0] exp);
        logic [5:0] d;
        d = got ^ exp;
        if (op <= 4'd3 || op == 4'd10) begin
            if (d[0]) return (op <= 4'd1) ? "R1" : "R2";
            if (d[5]) return "R3";
            if (d[2]) return "R5";
            return (op == 4'd10) ? "R7" : "R4";
        end
        if ((op == 4'd8 || op == 4'd9) && (d[1] || d[3] || d[4])) return "R4";
        return res_tag(op);
    endfunction

    // Called on a falling edge; returns on the falling edge one cycle later.
    task automatic do_op(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic        ew;
        logic [5:0]  ef;
        model(op, sz, a, b, mflags, er, ew, ef);
        op_valid = 1'b1; opcode = op; size = sz; opa = a; opb = b;
        #3;
        total++;
        if (result !== er || wr_en !== ew) begin
            bad++;
            $display("FAIL %s op=%0d size=%0d a=%h b=%h: actual result=%h wr=%b expected result=%h wr=%b",
                     res_tag(op), op, sz, a, b, result, wr_en, er, ew);
        end
        @(negedge clk);
        mflags = ef;
        total++;
        if (flags !== ef) begin
            bad++;
            $display("FAIL %s flags op=%0d size=%0d a=%h b=%h: actual=%b expected=%b",
                     flag_tag(op, flags, ef), op, sz, a, b, flags, ef);
        end
    endtask

    logic [31:0] bset [8];
    logic [31:0] wide [12];

    initial begin
        bset = '{32'h00, 32'h01, 32'h0F, 32'h10, 32'h7F, 32'h80, 32'hFE, 32'hFF};
        wide = '{32'h0, 32'h1, 32'h0000_000F, 32'h0000_7FFF, 32'h0000_8000, 32'h0000_FFFF,
                 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hA5A5_0F0F, 32'h0001_0000};
        @(negedge clk);
        // R13: reset state
        total++;
        if (flags !== 6'd0 || wr_en !== 1'b0 || result !== 32'd0) begin
            bad++;
            $display("FAIL R13 reset: actual flags=%b wr=%b result=%h expected flags=000000 wr=0 result=0",
                     flags, wr_en, result);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12: all ops, 8-bit near-exhaustive
        for (int a = 0; a < 256; a++)
            for (int bi = 0; bi < 8; bi++)
                for (int op = 0; op < 16; op++)
                    do_op(4'(op), 2'd0, 32'(a) | 32'hAB00, bset[bi] | 32'h5500);

        // wider sizes, including size code 3
        for (int sz = 1; sz < 4; sz++)
            for (int ai = 0; ai < 12; ai++)
                for (int bi = 0; bi < 12; bi++)
                    for (int op = 0; op < 16; op++)
                        do_op(4'(op), 2'(sz), wide[ai], wide[bi]);

        // R13: no valid means flags hold, nothing written
        do_op(4'd12, 2'd2, 32'h0, 32'h0);
        op_valid = 1'b0; opcode = 4'd11; opa = 32'hFF;
        #3;
        total++;
        if (wr_en !== 1'b0 || result !== 32'd0) begin
            bad++;
            $display("FAIL R13 idle outputs: actual wr=%b result=%h expected wr=0 result=0", wr_en, result);
        end
        @(negedge clk);
        total++;
        if (flags !== mflags) begin
            bad++;
            $display("FAIL R13 idle flags: actual=%b expected=%b", flags, mflags);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule